// File: doc/BRIEF.md
# Automatic Input Gain Controller

This block computes the 6-bit gain code for an input programmable-gain amplifier from the magnitude of the audio samples that come back from the converter. The code runs from -12 dB (code 0) to +35.25 dB (code 63) in 0.75 dB steps, with code 16 as unity. Each sample strobed in with its valid flag sets the measured level. On each timebase tick the controller compares that level with a target and then steps the gain down (attack), holds it, or steps it back up (decay). A fast overload path pulls the gain down on any near-full-scale sample without waiting for a tick. Programmable limits bound the gain, and a noise gate stops quiet background noise from pumping the gain up.

Two modes share the same gain code. In tracking mode the gain may rise anywhere up to the programmed maximum. In limiter mode it may only fall below the value it had when the mode took effect and return to that value. With the channel select at zero the controller is idle and the gain code stays where it was. Software can load a new code at any time.

Top module: `agc_engine`

## Requirements
- R1: After reset the gain output is code 16 (0 dB).
- R2: Channel select decoding: 00 gives both enables low, 01 raises only the right enable, 10 raises only the left enable, 11 raises both. The controller is active for any nonzero select.
- R3: While inactive, the gain output holds its value unless software writes it.
- R4: A software write loads the written code on the next clock edge, in any state, with priority over every other update. It also clears the hold, the step counter and the limiter ceiling reference (the ceiling becomes the written code).
- R5: The measured level is the absolute value of the latest valid sample, with the most negative value saturating to the largest positive one. The target magnitude for target code t is fullscale·m[k mod 4]/256 shifted right by k div 4, where k = 15 − t and m = {256, 215, 181, 152}. Code 0 is therefore -22.5 dBFS, and each code adds 1.5 dB.
- R6: On a tick with the level above the target, the gain drops one code each time ATK_BASE·2^attack consecutive attack ticks complete, and the hold timer reloads. Any change of step direction restarts the step count.
- R7: After the level falls to or below the target, the gain stays unchanged for the hold length in ticks: zero for hold code 0, otherwise HOLD_BASE·2^(code−1).
- R8: Once the hold has expired, with the level at or below the target and not gated, the gain rises one code every DCY_BASE·2^decay ticks.
- R9: A valid sample whose magnitude exceeds 7/8 of full scale lowers the gain by one code on that clock, with or without a tick. It also reloads the hold and restarts the step count.
- R10: While active, each update clamps the gain between 8·min (3-bit min code) and 7+8·max (3-bit max code).
- R11: In limiter mode (mode bit 1) the upper bound is additionally the gain at the moment the mode took effect, or at the last software write, whichever came later.
- R12: With the gate enabled and the level below fullscale >> (6+gate code), a tick does not change the gain and does not count down the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | SAMPLE_W | Signed audio sample |
| sampleValid | input | 1 | Sample strobe |
| tick | input | 1 | Timebase tick |
| cfgChanSel | input | 2 | Channel select / activity |
| cfgMode | input | 1 | 0 tracking, 1 limiter |
| cfgTarget | input | 4 | Target level code |
| cfgHold | input | 4 | Hold code |
| cfgAttack | input | 4 | Attack rate code |
| cfgDecay | input | 4 | Decay rate code |
| cfgMaxGain | input | 3 | Upper gain bound code |
| cfgMinGain | input | 3 | Lower gain bound code |
| cfgGateEn | input | 1 | Noise gate enable |
| cfgGateThr | input | 3 | Noise gate threshold code |
| swGainWr | input | 1 | Software gain write strobe |
| swGain | input | 6 | Software gain value |
| gainOut | output | 6 | Gain code |
| chanEnL | output | 1 | Left channel enable |
| chanEnR | output | 1 | Right channel enable |

## Verification
The assertions check on every cycle the properties that follow from one step alone: the bounds in tracking mode, the frozen gain while idle, the exact load on a software write, the one-code drop on an overload sample, and that neither an above-target level nor a gated level ever raises the gain. Only the bench's scenarios and its cycle-accurate model can show the behaviour that builds up over time: the attack and decay step periods, the hold length, the decay back up to the limiter ceiling and no further, and settling at the programmed bounds.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_W = 6;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = 6'd16;

  typedef enum logic [1:0] {DIR_NONE, DIR_ATK, DIR_DCY} dir_e;

  typedef struct packed {
    logic load;
    logic run;
    logic dec;
    logic inc;
  } gain_cmd_t;

  typedef struct packed {
    logic peakHit;
    logic above;
    logic gated;
  } level_flags_t;

  function automatic int quarterMant(input int frac);
    case (frac)
      0: return 256;
      1: return 215;
      2: return 181;
      default: return 152;
    endcase
  endfunction

  function automatic int targetMag(input int sampleW, input logic [3:0] code);
    int k;
    int full;
    k = 15 - int'(code);
    full = 1 << (sampleW - 1);
    return ((full * quarterMant(k % 4)) >> 8) >> (k / 4);
  endfunction

  function automatic int gateMag(input int sampleW, input logic [2:0] code);
    return (1 << (sampleW - 1)) >> (6 + int'(code));
  endfunction

  function automatic int peakMag(input int sampleW);
    int full;
    full = 1 << (sampleW - 1);
    return full - full / 8;
  endfunction

  function automatic int maxCode(input logic [2:0] code);
    return 7 + 8 * int'(code);
  endfunction

  function automatic int minCode(input logic [2:0] code);
    return 8 * int'(code);
  endfunction

  function automatic int clampGain(input int x, input int lo, input int hi);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic int holdTicks(input int base, input logic [3:0] code);
    if (code == 4'd0) return 0;
    return base << (int'(code) - 1);
  endfunction
endpackage

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int TMR_W     = 24,
  parameter int ATK_BASE  = 2,
  parameter int DCY_BASE  = 4,
  parameter int HOLD_BASE = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         active,
  input  logic         swWr,
  input  logic         tick,
  input  level_flags_t flags,
  input  logic [3:0]   cfgHold,
  input  logic [3:0]   cfgAttack,
  input  logic [3:0]   cfgDecay,
  output gain_cmd_t    cmd
);
  logic [TMR_W-1:0] holdQ, holdD, stepQ, stepD;
  logic [TMR_W-1:0] holdLen, atkPer, dcyPer, period, effCnt;
  dir_e dirQ, dirD, wantDir;

  assign holdLen = TMR_W'(holdTicks(HOLD_BASE, cfgHold));
  assign atkPer  = TMR_W'(ATK_BASE << cfgAttack);
  assign dcyPer  = TMR_W'(DCY_BASE << cfgDecay);

  always_comb begin
    cmd     = '0;
    holdD   = holdQ;
    stepD   = stepQ;
    dirD    = dirQ;
    wantDir = DIR_NONE;
    period  = '0;
    effCnt  = '0;
    if (swWr) begin
      cmd.load = 1'b1;
      holdD    = '0;
      stepD    = '0;
      dirD     = DIR_NONE;
    end else if (!active) begin
      holdD = '0;
      stepD = '0;
      dirD  = DIR_NONE;
    end else begin
      cmd.run = 1'b1;
      if (flags.peakHit) begin
        cmd.dec = 1'b1;
        holdD   = holdLen;
        stepD   = '0;
        dirD    = DIR_NONE;
      end else if (tick) begin
        if (flags.above) begin
          wantDir = DIR_ATK;
          holdD   = holdLen;
          period  = atkPer;
        end else if (flags.gated) begin
          wantDir = DIR_NONE;
        end else if (holdQ != '0) begin
          holdD = holdQ - 1'b1;
        end else begin
          wantDir = DIR_DCY;
          period  = dcyPer;
        end
        effCnt = (wantDir == dirQ) ? stepQ : '0;
        if (wantDir == DIR_NONE) begin
          stepD = '0;
        end else if (effCnt >= period - 1'b1) begin
          stepD   = '0;
          cmd.dec = (wantDir == DIR_ATK);
          cmd.inc = (wantDir == DIR_DCY);
        end else begin
          stepD = effCnt + 1'b1;
        end
        dirD = wantDir;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
      stepQ <= '0;
      dirQ  <= DIR_NONE;
    end else begin
      holdQ <= holdD;
      stepQ <= stepD;
      dirQ  <= dirD;
    end
  end
endmodule

// File: rtl/agc_datapath.sv
module agc_datapath
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic                       active,
  input  logic                       mode,
  input  logic [3:0]                 cfgTarget,
  input  logic                       cfgGateEn,
  input  logic [2:0]                 cfgGateThr,
  input  logic [2:0]                 cfgMaxGain,
  input  logic [2:0]                 cfgMinGain,
  input  logic [GAIN_W-1:0]          swGain,
  input  gain_cmd_t                  cmd,
  output level_flags_t               flags,
  output logic [GAIN_W-1:0]          gainQ
);
  localparam int PEAK_LVL = peakMag(SAMPLE_W);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] absNow, levelQ;
  logic [GAIN_W-1:0]   ceilQ, ceilEff;
  logic                limOnQ;
  int                  hiBase, hiEff, loEff, stepped, nextGain;

  always_comb begin
    if (sampleIn == MOST_NEG) absNow = MOST_POS;
    else if (sampleIn[SAMPLE_W-1]) absNow = SAMPLE_W'(-sampleIn);
    else absNow = sampleIn;
  end

  assign flags.peakHit = sampleValid && (int'(absNow) > PEAK_LVL);
  assign flags.above   = int'(levelQ) > targetMag(SAMPLE_W, cfgTarget);
  assign flags.gated   = cfgGateEn && (int'(levelQ) < gateMag(SAMPLE_W, cfgGateThr));

  assign ceilEff = limOnQ ? ceilQ : gainQ;

  always_comb begin
    hiBase = maxCode(cfgMaxGain);
    loEff  = minCode(cfgMinGain);
    hiEff  = hiBase;
    if (mode && int'(ceilEff) < hiBase) hiEff = int'(ceilEff);
    stepped  = int'(gainQ) - int'(cmd.dec) + int'(cmd.inc);
    nextGain = clampGain(stepped, loEff, hiEff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      gainQ  <= GAIN_UNITY;
      ceilQ  <= GAIN_UNITY;
      limOnQ <= 1'b0;
    end else begin
      if (sampleValid) levelQ <= absNow;
      if (cmd.load) gainQ <= swGain;
      else if (cmd.run) gainQ <= GAIN_W'(nextGain);
      if (cmd.load) ceilQ <= swGain;
      else if (active && mode && !limOnQ) ceilQ <= gainQ;
      limOnQ <= active && mode;
    end
  end
endmodule

// File: rtl/agc_engine.sv
module agc_engine
  import agc_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int TMR_W     = 24,
  parameter int ATK_BASE  = 2,
  parameter int DCY_BASE  = 4,
  parameter int HOLD_BASE = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic                       tick,
  input  logic [1:0]                 cfgChanSel,
  input  logic                       cfgMode,
  input  logic [3:0]                 cfgTarget,
  input  logic [3:0]                 cfgHold,
  input  logic [3:0]                 cfgAttack,
  input  logic [3:0]                 cfgDecay,
  input  logic [2:0]                 cfgMaxGain,
  input  logic [2:0]                 cfgMinGain,
  input  logic                       cfgGateEn,
  input  logic [2:0]                 cfgGateThr,
  input  logic                       swGainWr,
  input  logic [5:0]                 swGain,
  output logic [5:0]                 gainOut,
  output logic                       chanEnL,
  output logic                       chanEnR
);
  localparam int NUM_CH = 2;

  logic              active;
  logic [NUM_CH-1:0] chanEn;
  gain_cmd_t         cmd;
  level_flags_t      flags;

  assign active = |cfgChanSel;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chanEn
    assign chanEn[ch] = cfgChanSel[ch];
  end
  assign chanEnR = chanEn[0];
  assign chanEnL = chanEn[1];

  agc_ctrl #(
    .TMR_W(TMR_W), .ATK_BASE(ATK_BASE), .DCY_BASE(DCY_BASE), .HOLD_BASE(HOLD_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .swWr(swGainWr), .tick(tick),
    .flags(flags), .cfgHold(cfgHold), .cfgAttack(cfgAttack), .cfgDecay(cfgDecay),
    .cmd(cmd)
  );

  agc_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .active(active), .mode(cfgMode), .cfgTarget(cfgTarget), .cfgGateEn(cfgGateEn),
    .cfgGateThr(cfgGateThr), .cfgMaxGain(cfgMaxGain), .cfgMinGain(cfgMinGain),
    .swGain(swGain), .cmd(cmd), .flags(flags), .gainQ(gainOut)
  );
endmodule

// File: rtl/agc_checker.sv
module agc_checker
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic signed [SAMPLE_W-1:0] sampleIn,
  input logic                       sampleValid,
  input logic [1:0]                 cfgChanSel,
  input logic                       cfgMode,
  input logic [3:0]                 cfgTarget,
  input logic [2:0]                 cfgMaxGain,
  input logic [2:0]                 cfgMinGain,
  input logic                       cfgGateEn,
  input logic [2:0]                 cfgGateThr,
  input logic                       swGainWr,
  input logic [5:0]                 swGain,
  input logic [5:0]                 gainOut
);
  localparam int FULL = 1 << (SAMPLE_W - 1);

  int   magNow, lastMag, loC, hiC, tgtC, gateC;
  logic active;

  assign active = cfgChanSel != 2'b00;

  always_comb begin
    magNow = int'(sampleIn);
    if (magNow < 0) magNow = -magNow;
    if (magNow > FULL - 1) magNow = FULL - 1;
    loC   = 8 * int'(cfgMinGain);
    hiC   = 7 + 8 * int'(cfgMaxGain);
    tgtC  = targetMag(SAMPLE_W, cfgTarget);
    gateC = (FULL >> 6) >> int'(cfgGateThr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastMag <= 0;
    else if (sampleValid) lastMag <= magNow;
  end

  AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(active && !swGainWr && !cfgMode && loC <= hiC))
    |-> (int'(gainOut) >= $past(loC) && int'(gainOut) <= $past(hiC))); // R10

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!active && !swGainWr)) |-> $stable(gainOut)); // R3

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(swGainWr)) |-> gainOut == $past(swGain)); // R4

  AST_PEAK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(active && !swGainWr && !cfgMode && sampleValid &&
      magNow > FULL - FULL / 8 && int'(gainOut) > loC && int'(gainOut) <= hiC))
    |-> gainOut == $past(gainOut) - 6'd1); // R9

  AST_ATTACK_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(active && !swGainWr && lastMag > tgtC && int'(gainOut) >= loC))
    |-> gainOut <= $past(gainOut)); // R6

  AST_GATE_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(active && !swGainWr && cfgGateEn && lastMag < gateC &&
      int'(gainOut) >= loC))
    |-> gainOut <= $past(gainOut)); // R12
endmodule

bind agc_engine agc_checker #(.SAMPLE_W(SAMPLE_W)) u_agcChk (
  .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
  .cfgChanSel(cfgChanSel), .cfgMode(cfgMode), .cfgTarget(cfgTarget),
  .cfgMaxGain(cfgMaxGain), .cfgMinGain(cfgMinGain), .cfgGateEn(cfgGateEn),
  .cfgGateThr(cfgGateThr), .swGainWr(swGainWr), .swGain(swGain), .gainOut(gainOut)
);

// File: tb/agc_engine_tb.sv
`timescale 1ns/1ps
module agc_engine_tb;
  localparam int SW = 16;
  localparam int FULL = 1 << (SW - 1);
  localparam int ATK_B = 2, DCY_B = 4, HOLD_B = 4;

  logic clk = 0, rstN = 0;
  logic signed [SW-1:0] sampleIn = '0;
  logic sampleValid = 0, tick = 0;
  logic [1:0] cfgChanSel = 0;
  logic cfgMode = 0, cfgGateEn = 0, swGainWr = 0;
  logic [3:0] cfgTarget = 4'd8, cfgHold = 0, cfgAttack = 4'd2, cfgDecay = 4'd3;
  logic [2:0] cfgMaxGain = 3'd7, cfgMinGain = 0, cfgGateThr = 0;
  logic [5:0] swGain = 0;
  logic [5:0] gainOut;
  logic chanEnL, chanEnR;

  int errors = 0, checks = 0;
  string curTag = "R1";
  bit done = 0;

  // reference model state
  int mGain = 16, mLevel = 0, mHold = 0, mStep = 0, mDir = 0, mLimOn = 0, mCeil = 16;
  int s, a, lo, hi, ce, want, per, eff, g, tgtLvl, gateLvl, holdLen, k;
  int mant[4] = '{256, 215, 181, 152};

  always #2 clk = ~clk;

  agc_engine #(.SAMPLE_W(SW), .ATK_BASE(ATK_B), .DCY_BASE(DCY_B), .HOLD_BASE(HOLD_B)) u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid), .tick(tick),
    .cfgChanSel(cfgChanSel), .cfgMode(cfgMode), .cfgTarget(cfgTarget), .cfgHold(cfgHold),
    .cfgAttack(cfgAttack), .cfgDecay(cfgDecay), .cfgMaxGain(cfgMaxGain),
    .cfgMinGain(cfgMinGain), .cfgGateEn(cfgGateEn), .cfgGateThr(cfgGateThr),
    .swGainWr(swGainWr), .swGain(swGain), .gainOut(gainOut), .chanEnL(chanEnL),
    .chanEnR(chanEnR));

  function automatic int clampM(input int x, input int l, input int h);
    if (x > h) return h;
    if (x < l) return l;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mGain = 16; mLevel = 0; mHold = 0; mStep = 0; mDir = 0; mLimOn = 0; mCeil = 16;
    end else begin
      s = int'(sampleIn);
      a = (s < 0) ? -s : s;
      if (a > FULL - 1) a = FULL - 1;
      k = 15 - int'(cfgTarget);
      tgtLvl = ((FULL * mant[k % 4]) / 256) >> (k / 4);
      gateLvl = FULL >> (6 + int'(cfgGateThr));
      holdLen = (cfgHold == 0) ? 0 : HOLD_B << (int'(cfgHold) - 1);
      lo = 8 * int'(cfgMinGain);
      hi = 7 + 8 * int'(cfgMaxGain);
      ce = mLimOn ? mCeil : mGain;
      if (cfgMode && ce < hi) hi = ce;
      g = mGain;
      if (swGainWr) begin
        mCeil = int'(swGain);
        g = int'(swGain); mHold = 0; mStep = 0; mDir = 0;
      end else begin
        if (cfgChanSel != 0 && cfgMode && mLimOn == 0) mCeil = mGain;
        if (cfgChanSel == 0) begin
          mHold = 0; mStep = 0; mDir = 0;
        end else if (sampleValid && a > FULL - FULL / 8) begin
          g = clampM(mGain - 1, lo, hi); mHold = holdLen; mStep = 0; mDir = 0;
        end else if (tick) begin
          want = 0; per = 0;
          if (mLevel > tgtLvl) begin want = 1; mHold = holdLen; per = ATK_B << cfgAttack; end
          else if (cfgGateEn && mLevel < gateLvl) want = 0;
          else if (mHold != 0) mHold = mHold - 1;
          else begin want = 2; per = DCY_B << cfgDecay; end
          eff = (want == mDir) ? mStep : 0;
          if (want == 0) mStep = 0;
          else if (eff >= per - 1) begin
            mStep = 0;
            g = (want == 1) ? mGain - 1 : mGain + 1;
          end else mStep = eff + 1;
          mDir = want;
          g = clampM(g, lo, hi);
        end else begin
          g = clampM(mGain, lo, hi);
        end
      end
      mGain = g;
      mLimOn = (cfgChanSel != 0 && cfgMode) ? 1 : 0;
      if (sampleValid) mLevel = a;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (int'(gainOut) != mGain) begin
        errors++;
        $display("FAIL %s: model compare gainOut=%0d expected=%0d", curTag, gainOut, mGain);
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int amp, input bit vld, input bit tk, input int n);
    sampleIn = SW'(amp); sampleValid = vld; tick = tk;
    repeat (n) @(negedge clk);
  endtask

  task automatic swWrite(input int v);
    swGain = 6'(v); swGainWr = 1;
    @(negedge clk);
    swGainWr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int gAfter;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset gain", gainOut == 6'd16, gainOut, 16);
    rstN = 1;
    @(negedge clk);
    chk("R1 gain after reset release", gainOut == 6'd16, gainOut, 16);

    curTag = "R2";
    cfgChanSel = 2'b00; #1 chk("R2 sel00", {chanEnL, chanEnR} == 2'b00, {chanEnL, chanEnR}, 0);
    cfgChanSel = 2'b01; #1 chk("R2 sel01", {chanEnL, chanEnR} == 2'b01, {chanEnL, chanEnR}, 1);
    cfgChanSel = 2'b10; #1 chk("R2 sel10", {chanEnL, chanEnR} == 2'b10, {chanEnL, chanEnR}, 2);
    cfgChanSel = 2'b11; #1 chk("R2 sel11", {chanEnL, chanEnR} == 2'b11, {chanEnL, chanEnR}, 3);
    cfgChanSel = 2'b00;
    @(negedge clk);

    curTag = "R3";
    drive(30000, 1, 1, 20);
    chk("R3 idle gain frozen", gainOut == 6'd16, gainOut, 16);

    curTag = "R4";
    swWrite(33);
    chk("R4 write while idle", gainOut == 6'd33, gainOut, 33);
    swWrite(40);

    curTag = "R6";
    cfgChanSel = 2'b11; cfgAttack = 0; cfgDecay = 0; cfgHold = 0;
    drive(20000, 1, 1, 20);
    chk("R6 attack lowers gain", gainOut < 6'd40, gainOut, 39);

    curTag = "R8";
    cfgMaxGain = 3'd5;
    drive(1000, 1, 1, 150);
    chk("R8 R10 decay to max bound", gainOut == 6'd47, gainOut, 47);

    curTag = "R7";
    cfgHold = 4'd3;
    drive(20000, 1, 1, 2);
    drive(1000, 1, 1, 2);
    gAfter = int'(gainOut);
    drive(1000, 1, 1, 10);
    chk("R7 hold keeps gain", int'(gainOut) == gAfter, gainOut, gAfter);
    drive(1000, 1, 1, 30);
    chk("R8 decay after hold", int'(gainOut) > gAfter, gainOut, gAfter + 1);

    curTag = "R9";
    drive(1000, 1, 1, 100);
    chk("R9 back at max", gainOut == 6'd47, gainOut, 47);
    drive(30000, 1, 0, 3);
    chk("R9 overload drops one per sample", gainOut == 6'd44, gainOut, 44);

    curTag = "R5";
    drive(-32768, 1, 0, 1);
    chk("R5 most negative saturates as overload", gainOut == 6'd43, gainOut, 43);

    curTag = "R12";
    cfgHold = 0; cfgGateEn = 1; cfgGateThr = 0;
    drive(100, 1, 1, 2);
    chk("R12 gate baseline", gainOut == 6'd43, gainOut, 43);
    drive(100, 1, 1, 60);
    chk("R12 gated no rise", gainOut == 6'd43, gainOut, 43);

    curTag = "R11";
    cfgGateEn = 0; cfgMode = 1;
    sampleIn = 16'sd1000; sampleValid = 1; tick = 1;
    swWrite(20);
    drive(1000, 1, 1, 150);
    chk("R11 limiter no rise past start", gainOut == 6'd20, gainOut, 20);
    drive(20000, 1, 1, 20);
    chk("R11 limiter reduces loud", gainOut < 6'd20, gainOut, 19);
    drive(1000, 1, 1, 150);
    chk("R11 limiter returns to ceiling", gainOut == 6'd20, gainOut, 20);

    curTag = "R10";
    cfgMode = 0; cfgMinGain = 3'd2;
    drive(20000, 1, 1, 200);
    chk("R10 clamp at min bound", gainOut == 6'd16, gainOut, 16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule